// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one burst access to a synchronous DRAM page. A start pulse captures a starting column together with the burst configuration: length code, ordering (sequential or interleaved), read/write direction and a single-beat-write flag. From the following cycle the block presents one column address per clock, with a valid strobe, until the burst completes or is cut short.

Bursts of fixed length wrap inside their aligned length-sized block of columns. A full-page burst walks every column of the page, wraps from the top column to column 0, and ends only when the terminate input is asserted. A new start is accepted on any cycle and replaces whatever burst is in progress. This matches the rule that a new random column can be issued every clock. The terminate input covers both ways of ending a burst early (burst stop and precharge).

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and with no start, `valid_o` and `last_o` are low.
- R2: A start sampled on a rising edge makes the first beat appear in the following cycle, with `valid_o` high and `col_o` equal to the captured start column.
- R3: The length code `blen_i` selects 1, 2, 4 or 8 beats for codes 0, 1, 2 and 3, and full page for code 7. Codes 4 to 6 behave as 1 beat. In sequential order (`burst_type_i`=0), beat i has its low log2(BL) column bits equal to (start low bits + i) mod BL, and its upper bits equal to those of the start column.
- R4: In interleaved order (`burst_type_i`=1), beat i has its low log2(BL) bits equal to the start column's low bits XOR i, and its upper bits unchanged.
- R5: `last_o` is high on beat BL-1 only. For BL=1 it is high on the first and only beat. `valid_o` falls in the cycle after the last beat unless a new start was sampled.
- R6: A full-page burst uses sequential order regardless of `burst_type_i`. It increments the column by one per beat, wraps from 2^COL_W-1 to 0, never raises `last_o`, and runs until terminated.
- R7: `term_i` sampled high during an active burst, without a start, makes `valid_o` low in the next cycle.
- R8: A start sampled during an active burst restarts the sequence from the new start column in the next cycle, even when `term_i` is high at the same edge.
- R9: When `single_write_i` is 1, a write burst (`write_i`=1) has exactly one beat whatever the length code, while a read keeps the programmed length.
- R10: The configuration inputs are captured at start, and changing them during a burst has no effect on the addresses of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | Starting column |
| write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| blen_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| single_write_i | input | 1 | Forces write bursts to one beat |
| term_i | input | 1 | End the active burst early |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Current beat is the final one |

## Verification
The first beat is due one clock after the edge that samples the start, and each later beat follows on successive clocks. A terminate or restart sampled on an edge shows at the outputs in the cycle after that edge. The bench runs a behavioural model on the same rising edge as the design, using block offsets and modulo arithmetic. It compares all three outputs at the following falling edge, so every expected value is checked exactly one register stage after its stimulus.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             write_i,
  input  logic [2:0]       blen_i,
  input  logic             burst_type_i,
  input  logic             single_write_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             one_beat;

  assign one_beat = write_i & single_write_i;

  always_comb begin
    full_d = 1'b0;
    mask_d = '0;
    if (!one_beat) begin
      case (blen_i)
        3'd1: mask_d = COL_W'(1);
        3'd2: mask_d = COL_W'(3);
        3'd3: mask_d = COL_W'(7);
        3'd7: begin
          full_d = 1'b1;
          mask_d = '1;
        end
        default: mask_d = '0;
      endcase
    end
  end

  assign col_o   = (base_q & ~mask_q) |
                   ((ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q)) & mask_q);
  assign valid_o = active_q;
  assign last_o  = active_q & ~full_q & (cnt_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_d;
      ilv_q    <= burst_type_i & ~full_d;
      base_q   <= start_col_i;
      cnt_q    <= '0;
      mask_q   <= mask_d;
    end else if (active_q) begin
      if (term_i || last_o) active_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !valid_o && !last_o);

  // R2 / R8
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  // R5
  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  p_drop_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);

  // R6
  p_full_never_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && full_q |-> !last_o);

  // R7
  p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && term_i && !start_i |=> !valid_o);

  // R9
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && write_i && single_write_i |=> last_o);

  // R10
  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !start_i |=> $stable(base_q) && $stable(mask_q) && $stable(ilv_q));

endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
  localparam int COL_W = 9;
  localparam int COLS  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic write_i = 1'b0;
  logic [2:0] blen_i = 3'd0;
  logic burst_type_i = 1'b0;
  logic single_write_i = 1'b0;
  logic term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .write_i(write_i), .blen_i(blen_i), .burst_type_i(burst_type_i),
    .single_write_i(single_write_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_active = 0, m_base = 0, m_beat = 0, m_len = 1, m_ilv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0;
    end else if (start_i) begin
      m_active = 1;
      m_beat = 0;
      m_base = int'(start_col_i);
      if (write_i && single_write_i) m_len = 1;
      else if (blen_i == 3'd7) m_len = 0;
      else if (blen_i <= 3'd3) m_len = 1 << blen_i;
      else m_len = 1;
      m_ilv = (burst_type_i && m_len != 0) ? 1 : 0;
    end else if (m_active != 0) begin
      if (term_i || (m_len != 0 && m_beat == m_len - 1)) m_active = 0;
      else m_beat++;
    end
  end

  function automatic int exp_col();
    int blk, off;
    if (m_len == 0) return (m_base + m_beat) % COLS;
    blk = m_base - (m_base % m_len);
    off = m_base % m_len;
    if (m_ilv != 0) return blk + (off ^ m_beat);
    return blk + ((off + m_beat) % m_len);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int ev, el, ec;
      ev = m_active;
      el = (m_active != 0 && m_len != 0 && m_beat == m_len - 1) ? 1 : 0;
      ec = exp_col();
      checks++;
      if (int'(valid_o) != ev || int'(last_o) != el || (ev != 0 && int'(col_o) != ec)) begin
        failures++;
        $display("FAIL %s valid=%0d last=%0d col=%0d expected valid=%0d last=%0d col=%0d",
                 cur_req, valid_o, last_o, col_o, ev, el, ec);
      end
    end
  end

  task automatic go(input int col, input bit wr, input int bl, input bit typ, input bit sw);
    @(negedge clk); #1;
    start_i = 1'b1; start_col_i = COL_W'(col); write_i = wr;
    blen_i = 3'(bl); burst_type_i = typ; single_write_i = sw;
    @(negedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 valid=%0b last=%0b expected 0 0", valid_o, last_o);
    end
    #1 rst_n = 1'b1;
    idle(3);

    cur_req = "R2"; go(37, 0, 2, 0, 0); idle(5);
    cur_req = "R3"; go(13, 0, 3, 0, 0); idle(9);
    go(6, 0, 2, 0, 0); idle(5);
    go(511, 0, 1, 0, 0); idle(3);
    go(100, 0, 5, 0, 0); idle(3);
    cur_req = "R4"; go(13, 0, 3, 1, 0); idle(9);
    go(2, 0, 2, 1, 0); idle(5);
    cur_req = "R5"; go(200, 0, 0, 0, 0); idle(3);
    go(201, 1, 1, 1, 0); idle(3);
    cur_req = "R6"; go(508, 0, 7, 1, 0); idle(8);
    @(negedge clk); #1 term_i = 1'b1; @(negedge clk); #1 term_i = 1'b0; idle(3);
    cur_req = "R7"; go(40, 0, 3, 0, 0); idle(2);
    term_i = 1'b1; @(negedge clk); #1 term_i = 1'b0; idle(3);
    cur_req = "R8"; go(16, 0, 3, 0, 0); idle(2);
    term_i = 1'b1; go(300, 0, 2, 1, 0); term_i = 1'b0; idle(1);
    go(77, 0, 3, 0, 0); idle(6);
    cur_req = "R9"; go(90, 1, 3, 0, 1); idle(3);
    go(90, 0, 3, 0, 1); idle(9);
    go(91, 1, 7, 0, 1); idle(3);
    cur_req = "R10"; go(21, 0, 3, 1, 0);
    blen_i = 3'd7; burst_type_i = 1'b0; start_col_i = 9'd0; write_i = 1'b1; single_write_i = 1'b1;
    idle(9);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule